// File: doc/BRIEF.md
# Byte-Serial Auto-Increment SRAM Bridge

This block connects a host with very few spare pins to an asynchronous static RAM of 512K bytes. The host needs only eleven wires: an 8-bit data port, a 2-bit select field and a strobe line. The bridge samples the strobe in its own clock domain and acts once on each rising edge. The select field tells it what the edge means: load one byte of the pointer, accept a command byte, or move one data byte.

The host first writes the low and then the high byte of a 16-bit pointer. It then sends a command that puts the bridge in read mode or write mode. From then on, each data strobe moves one byte and advances the pointer by one. No further address setup is needed. Only the low 16 pointer bits can be loaded. The upper part of memory is reached by stepping the pointer upward past 0xFFFF, and the carry runs into bits 18..16. The 19-bit pointer wraps from 0x7FFFF back to zero.

The host must leave enough time between strobe edges for the previous memory access to finish. That is roughly a dozen bridge clock cycles.

Top module: `sram_stream_bridge`

## Requirements
- R1: After reset, all memory strobes (mem_ce_n, mem_oe_n, mem_we_n) are high. Both data drive enables are low, and mem_addr is zero.
- R2: A strobe with select 00 loads the host byte into pointer bits 7..0. A strobe with select 01 loads it into bits 15..8. Either load clears pointer bits 18..16 and leaves the bridge with no mode.
- R3: A strobe with select 10 is a command. Host bit 0 = 1 selects read mode, and bit 0 = 0 selects write mode. The other bits are ignored.
- R4: hst_data_oe is high only when the bridge is in read mode and the select field is 11. It changes one bridge clock after the select field.
- R5: In read mode, hst_data_o presents the byte at the current pointer before the next strobe. A select-11 strobe advances the pointer by one and fetches the byte at the new address.
- R6: In write mode, a select-11 strobe captures the host byte. The byte is written to the current pointer with mem_we_n low for exactly one clock, with mem_ce_n low and mem_addr and mem_dq_o held steady. The pointer then advances by one.
- R7: Stepping the pointer from 0xFFFF gives 0x10000. The carry reaches the address bits above the loadable range.
- R8: A select-11 strobe while no mode is set, either after reset or after a pointer load, causes no memory access and leaves the pointer unchanged.
- R9: Each strobe acts once, on its rising edge only. A strobe held high for a long time produces exactly one transfer.
- R10: mem_oe_n is never low while the bridge drives mem_dq_o (mem_dq_oe high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_stb | input | 1 | Host strobe; acts on its rising edge |
| hst_sel | input | 2 | Host select: 00 pointer low, 01 pointer high, 10 command, 11 data |
| hst_data_i | input | 8 | Byte from host |
| hst_data_o | output | 8 | Byte to host (read mode) |
| hst_data_oe | output | 1 | Drive enable for the host data port toward the host |
| mem_addr | output | 19 | SRAM address |
| mem_dq_i | input | 8 | Byte from SRAM |
| mem_dq_o | output | 8 | Byte to SRAM |
| mem_dq_oe | output | 1 | Drive enable for the SRAM data bus |
| mem_ce_n | output | 1 | SRAM chip select, active low |
| mem_oe_n | output | 1 | SRAM output enable, active low |
| mem_we_n | output | 1 | SRAM write enable, active low |

## Verification
A wrong pointer shows up at once on mem_addr during the next access. In read mode it also shows up on hst_data_o within about ten clocks of the strobe, because the byte fetched then comes from the wrong location. A wrong mode shows up in different ways: as a write pulse where none should occur, as a missing write, or as hst_data_oe asserting while the bridge is not in read mode. Upper-bit errors, such as a missing carry or upper bits that are not cleared on a load, are exposed by reading back across the 0xFFFF boundary and then reloading the low byte. These checks compare against bytes that the bench itself tracks.

// File: rtl/sbridge_pkg.sv
`timescale 1ns/1ps
package sbridge_pkg;
  localparam int PTR_LOAD_BYTES = 2;

  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'b00,
    SEL_PTR_HI = 2'b01,
    SEL_CMD    = 2'b10,
    SEL_XFER   = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_RD   = 2'd1,
    MODE_WR   = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    MS_IDLE = 3'd0,
    MS_RD   = 3'd1,
    MS_WSET = 3'd2,
    MS_WPUL = 3'd3,
    MS_WEND = 3'd4
  } mseq_e;
endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
// Brings the host strobe into the bridge clock and emits a one-cycle pulse per rising edge.
module strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stb_in,
  output logic rise
);
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      rise  <= 1'b0;
    end else begin
      chain <= {chain[SYNC_STAGES-1:0], stb_in};
      rise  <= chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    end
  end
endmodule

// File: rtl/ptr_unit.sv
`timescale 1ns/1ps
// Address pointer: byte-lane loads of the low part, upper bits cleared on load, +1 stepping.
module ptr_unit
  import sbridge_pkg::*;
#(
  parameter int PTR_W  = 19,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PTR_LOAD_BYTES-1:0] ld_en,
  input  logic [BYTE_W-1:0]         ld_byte,
  input  logic                      inc,
  output logic [PTR_W-1:0]          ptr
);
  localparam int LOAD_W = BYTE_W * PTR_LOAD_BYTES;
  localparam int HI_W   = PTR_W - LOAD_W;
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [LOAD_W-1:0] lo_next;

  generate
    for (genvar g = 0; g < PTR_LOAD_BYTES; g++) begin : g_lane
      assign lo_next[g*BYTE_W +: BYTE_W] = ld_en[g] ? ld_byte : ptr[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (|ld_en) begin
      ptr <= {{HI_W{1'b0}}, lo_next};
    end else if (inc) begin
      ptr <= ptr + ONE;
    end
  end
endmodule

// File: rtl/mem_seq.sv
`timescale 1ns/1ps
// Drives one asynchronous SRAM access at a time with registered strobes.
module mem_seq
  import sbridge_pkg::*;
#(
  parameter int PTR_W   = 19,
  parameter int BYTE_W  = 8,
  parameter int RD_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic              wr_go,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [PTR_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0] mem_dq_i,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [BYTE_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              wr_done
);
  localparam int CNT_W = $clog2(RD_WAIT + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  mseq_e          state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MS_IDLE;
      cnt       <= '0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      rd_byte   <= '0;
      wr_done   <= 1'b0;
    end else begin
      wr_done <= 1'b0;
      unique case (state)
        MS_IDLE: begin
          if (rd_go) begin
            mem_addr <= addr_i;
            mem_ce_n <= 1'b0;
            mem_oe_n <= 1'b0;
            cnt      <= CNT_W'(RD_WAIT);
            state    <= MS_RD;
          end else if (wr_go) begin
            mem_addr  <= addr_i;
            mem_dq_o  <= wr_byte;
            mem_dq_oe <= 1'b1;
            mem_ce_n  <= 1'b0;
            state     <= MS_WSET;
          end
        end
        MS_RD: begin
          if (cnt == '0) begin
            rd_byte  <= mem_dq_i;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            state    <= MS_IDLE;
          end else begin
            cnt <= cnt - CNT_ONE;
          end
        end
        MS_WSET: begin
          mem_we_n <= 1'b0;
          state    <= MS_WPUL;
        end
        MS_WPUL: begin
          mem_we_n <= 1'b1;
          state    <= MS_WEND;
        end
        MS_WEND: begin
          mem_ce_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          wr_done   <= 1'b1;
          state     <= MS_IDLE;
        end
        default: state <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_stream_bridge.sv
`timescale 1ns/1ps
module sram_stream_bridge
  import sbridge_pkg::*;
#(
  parameter int PTR_W       = 19,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RD_WAIT     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_stb,
  input  logic [1:0]        hst_sel,
  input  logic [BYTE_W-1:0] hst_data_i,
  output logic [BYTE_W-1:0] hst_data_o,
  output logic              hst_data_oe,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic [BYTE_W-1:0] mem_dq_i,
  output logic [BYTE_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);
  logic                      rise;
  mode_e                     mode;
  sel_e                      sel;
  logic                      fetch_q;
  logic                      oe_q;
  logic [PTR_LOAD_BYTES-1:0] ld_en;
  logic                      rd_step;
  logic                      wr_go;
  logic                      wr_done;
  logic [PTR_W-1:0]          ptr;

  assign sel = sel_e'(hst_sel);

  strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .stb_in (hst_stb),
    .rise   (rise)
  );

  // Strobe decode
  assign ld_en[0] = rise && (sel == SEL_PTR_LO);
  assign ld_en[1] = rise && (sel == SEL_PTR_HI);
  assign rd_step  = rise && (sel == SEL_XFER) && (mode == MODE_RD);
  assign wr_go    = rise && (sel == SEL_XFER) && (mode == MODE_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_IDLE;
      fetch_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      fetch_q <= 1'b0;
      if (rise) begin
        unique case (sel)
          SEL_PTR_LO, SEL_PTR_HI: mode <= MODE_IDLE;
          SEL_CMD: begin
            mode    <= hst_data_i[0] ? MODE_RD : MODE_WR;
            fetch_q <= hst_data_i[0];
          end
          SEL_XFER: if (mode == MODE_RD) fetch_q <= 1'b1;
          default: ;
        endcase
      end
      oe_q <= (mode == MODE_RD) && (sel == SEL_XFER);
    end
  end

  assign hst_data_oe = oe_q;

  ptr_unit #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (ld_en),
    .ld_byte (hst_data_i),
    .inc     (rd_step | wr_done),
    .ptr     (ptr)
  );

  mem_seq #(.PTR_W(PTR_W), .BYTE_W(BYTE_W), .RD_WAIT(RD_WAIT)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .rd_go     (fetch_q),
    .wr_go     (wr_go),
    .wr_byte   (hst_data_i),
    .addr_i    (ptr),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .rd_byte   (hst_data_o),
    .wr_done   (wr_done)
  );
endmodule

// File: rtl/sram_stream_bridge_chk.sv
`timescale 1ns/1ps
module sram_stream_bridge_chk #(
  parameter int PTR_W  = 19,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        hst_sel,
  input logic              hst_data_oe,
  input logic [PTR_W-1:0]  mem_addr,
  input logic [BYTE_W-1:0] mem_dq_o,
  input logic              mem_dq_oe,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n
);
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !hst_data_oe));

  p_host_oe_sel_r4: assert property (@(posedge clk) disable iff (rst)
    hst_data_oe |-> ($past(hst_sel) == 2'b11));

  p_we_single_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |=> mem_we_n);

  p_we_selected_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  p_we_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  p_no_contend_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));
endmodule

bind sram_stream_bridge sram_stream_bridge_chk #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hst_sel     (hst_sel),
  .hst_data_oe (hst_data_oe),
  .mem_addr    (mem_addr),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe   (mem_dq_oe),
  .mem_ce_n    (mem_ce_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n)
);

// File: tb/sram_stream_bridge_tb_top.sv
`timescale 1ns/1ps
module sram_stream_bridge_tb_top;
  localparam int PTR_W = 19;
  localparam int MASK  = (1 << PTR_W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stb = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic [7:0]  din = 8'h00;
  logic [7:0]  hst_data_o;
  logic        hst_data_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_i = 8'h00;
  logic [7:0]  mem_dq_o;
  logic        mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sram_stream_bridge dut_i (
    .clk(clk), .rst(rst), .hst_stb(stb), .hst_sel(sel), .hst_data_i(din),
    .hst_data_o(hst_data_o), .hst_data_oe(hst_data_oe), .mem_addr(mem_addr),
    .mem_dq_i(mem_dq_i), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  // SRAM model fed from the pins, and a separate reference memory fed from host actions.
  logic [7:0] sram_mem [int];
  logic [7:0] ref_mem  [int];
  int wr_cnt = 0;
  int last_wr_addr = 0;
  int last_wr_data = 0;
  int contend = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ {5'(a >> 16), 3'b101} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ref_rd(input int a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return pat(a);
  endfunction

  always @(negedge clk) begin
    int a;
    a = int'(mem_addr);
    if (!mem_we_n) begin
      sram_mem[a] = mem_dq_o;
      wr_cnt++;
      last_wr_addr = a;
      last_wr_data = int'(mem_dq_o);
    end
    if (mem_dq_oe && !mem_oe_n) contend++;
    mem_dq_i <= sram_mem.exists(a) ? sram_mem[a] : pat(a);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [1:0] s, input logic [7:0] d, input int hold);
    @(posedge clk); #1;
    sel = s; din = d;
    repeat (2) @(posedge clk); #1;
    stb = 1'b1;
    repeat (hold) @(posedge clk); #1;
    stb = 1'b0;
    repeat (10) @(posedge clk); #1;
  endtask

  int exp_ptr = 0;

  task automatic load_ptr(input int p);
    strobe(2'b00, 8'(p), 6);
    strobe(2'b01, 8'(p >> 8), 6);
    exp_ptr = p & 16'hFFFF;
  endtask

  task automatic cmd(input bit rd);
    logic [7:0] c;
    c = {7'($urandom), rd};   // R3: only bit 0 matters
    strobe(2'b10, c, 6);
  endtask

  task automatic read_byte(input string tag);
    @(posedge clk); #1;
    sel = 2'b11;
    repeat (2) @(posedge clk); #1;
    chk(hst_data_oe == 1'b1, "R4 oe in read/data", int'(hst_data_oe), 1);
    chk(hst_data_o == ref_rd(exp_ptr), tag, int'(hst_data_o), int'(ref_rd(exp_ptr)));
    strobe(2'b11, 8'h00, 6);
    exp_ptr = (exp_ptr + 1) & MASK;
  endtask

  task automatic write_byte(input logic [7:0] d, input int hold);
    int c0;
    c0 = wr_cnt;
    strobe(2'b11, d, hold);
    chk(wr_cnt == c0 + 1, "R6/R9 one write per strobe", wr_cnt - c0, 1);
    chk(last_wr_addr == exp_ptr, "R6 write address", last_wr_addr, exp_ptr);
    chk(last_wr_data == int'(d), "R6 write data", last_wr_data, int'(d));
    ref_mem[exp_ptr] = d;
    exp_ptr = (exp_ptr + 1) & MASK;
  endtask

  task automatic finish_run;
    chk(contend == 0, "R10 no bus contention", contend, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !hst_data_oe, "R1 enables low", {mem_dq_oe, hst_data_oe}, 0);
    chk(mem_addr == '0, "R1 addr zero", int'(mem_addr), 0);

    // R8: data strobe with no mode after reset does nothing
    begin
      int c0;
      c0 = wr_cnt;
      strobe(2'b11, 8'hAA, 6);
      chk(wr_cnt == c0, "R8 no access after reset", wr_cnt - c0, 0);
      chk(mem_ce_n == 1'b1, "R8 chip idle", int'(mem_ce_n), 1);
    end

    // R2/R3/R6 directed writes, then R5 readback
    load_ptr(16'h1234);
    cmd(1'b0);
    write_byte(8'h11, 6);
    write_byte(8'h22, 6);
    write_byte(8'h33, 40);  // R9 long strobe
    // R8: pointer load cancels mode; following data strobe ignored
    load_ptr(16'h1234);
    begin
      int c0;
      c0 = wr_cnt;
      strobe(2'b11, 8'h99, 6);
      chk(wr_cnt == c0, "R8 no write after load", wr_cnt - c0, 0);
    end
    cmd(1'b1);
    chk(hst_data_oe == 1'b0, "R4 oe low on command select", int'(hst_data_oe), 0);
    chk(mem_addr == 19'h01234, "R8 pointer not stepped", int'(mem_addr), 32'h1234);
    read_byte("R5 read back 1");
    read_byte("R5 read back 2");
    read_byte("R5 read back 3");
    read_byte("R5 read unwritten");

    // R4: write mode with select 11 keeps oe low
    cmd(1'b0);
    @(posedge clk); #1; sel = 2'b11;
    repeat (3) @(posedge clk); #1;
    chk(hst_data_oe == 1'b0, "R4 oe low in write mode", int'(hst_data_oe), 0);

    // R7 carry past 0xFFFF, then R2 upper-bit clear
    load_ptr(16'hFFFF);
    cmd(1'b1);
    read_byte("R7 byte at FFFF");
    chk(mem_addr == 19'h10000, "R7 carry into bit 16", int'(mem_addr), 32'h10000);
    chk(hst_data_o == ref_rd(32'h10000), "R7 byte above 64K", int'(hst_data_o), int'(ref_rd(32'h10000)));
    cmd(1'b0);
    write_byte(8'hC3, 6);
    chk(last_wr_addr == 32'h10000, "R7 write above 64K", last_wr_addr, 32'h10000);
    strobe(2'b00, 8'h00, 6);  // ptr[15:8] is 0 here
    exp_ptr = 0;
    cmd(1'b1);
    chk(mem_addr == '0, "R2 upper bits cleared", int'(mem_addr), 0);
    read_byte("R2 byte at zero");
    load_ptr(16'hFFFF);
    cmd(1'b1);
    read_byte("R7 readback FFFF");
    read_byte("R7 readback 10000");

    // Random phase in a small window so reads hit written bytes
    for (int it = 0; it < 40; it++) begin
      int n;
      bit rd;
      load_ptr(int'($urandom_range(0, 255)) | 32'h0300);
      rd = 1'($urandom);
      n  = int'($urandom_range(1, 6));
      cmd(rd);
      for (int k = 0; k < n; k++) begin
        if (rd) read_byte("R5 random read");
        else    write_byte(8'($urandom), int'($urandom_range(3, 20)));
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule